// File: doc/BRIEF.md
# I2C Indexed Block Register Target

This block is an I2C target that exposes a bank of 8-bit configuration registers to a bus host. A write transfer names a starting register index and an explicit byte count, then streams that many data bytes into consecutive registers. A read transfer ignores any index. It always returns the current length value first, then that many registers starting at register 0.

Both bus lines pass through two-flop synchronizers. START and STOP are taken from SDA edges while SCL is high. The target only pulls SDA low and never drives it high, so the bus stays open-drain.

Each stored data byte also appears for one cycle on a write port made of an address, the data and a strobe, so logic nearby can follow the bank. Some fields are read-only and come straight from input pins: a device identifier, a vendor identifier and a set of latched strap bits.

Top module: `i2c_idx_regs`

## Requirements
- R1: The target acknowledges only the 8-bit address bytes 0xD2 (write) and 0xD3 (read). After any other address byte it leaves SDA released for the rest of the transfer and stores nothing until the next START.
- R2: A write is the address, then a start index N, then a count X, then X data bytes. Data byte k is stored at register N+k and produces exactly one single-cycle strobe on the write port. Every byte of a matched write is acknowledged.
- R3: Data bytes beyond the count X, and data bytes aimed at an index at or above the number of registers (24 by default), are acknowledged but change no register and raise no strobe.
- R4: A read is a START and the address 0xD3. The target first sends the length held in register 8, then registers 0, 1, 2, ... in order, whatever index an earlier write named. Indices at or above the number of registers read as 0x00.
- R5: Register 8 resets to 0x0F and sets how many register bytes a read returns. Bytes the host requests beyond that length read as 0xFF.
- R6: Register 7 always reads as the device-identifier input. Bits [3:0] of register 6 always read as the vendor-identifier input. Writes do not change these fields, and bits [7:4] of register 6 remain writable.
- R7: Bits [4:0] of register 1 always read as the strap input. Bits [7:5] of register 1 remain writable.
- R8: When the host answers a read byte with a not-acknowledge, the target stops sending and keeps SDA released until the next START.
- R9: During reset SDA is released and the strobe is low. After reset every writable register reads 0x00, except register 8.
- R10: The target changes its SDA drive only while SCL is low. A START in the middle of a transfer, including a repeated START, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, well above the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_en_o | output | 1 | One-cycle strobe for each stored data byte |
| wr_addr_o | output | 8 | Register index of the stored byte |
| wr_data_o | output | 8 | Value of the stored byte |
| dev_id_i | input | 8 | Device identifier returned by register 7 |
| vendor_id_i | input | 4 | Vendor identifier returned by register 6 bits [3:0] |
| strap_i | input | 5 | Latched strap levels returned by register 1 bits [4:0] |

## Verification
The bound checker watches four properties on every cycle. The target moves SDA only while SCL is low. Each write strobe lasts one cycle and carries an index inside the bank. No strobe fires while a byte is being sent. Both lines are quiet during reset. Only the bench scenarios can show the byte-level behaviour: which addresses are acknowledged, where written bytes land and which ones are dropped, the length-first read order with its 0xFF and 0x00 fill, the read-only overlays, and recovery after a not-acknowledge or a repeated START. For these the bench sweeps every register index and every strap value against its own model.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_RACK
   } xfer_st_t;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_INDEX,
      PH_COUNT,
      PH_DATA
   } wr_ph_t;
endpackage

// File: rtl/i2cx_sync.sv
module i2cx_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2cx_sync needs at least two stages");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '1;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cx_cond.sv
module i2cx_cond #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic sda_s
);
   logic [1:0] lines;
   logic       scl_p, sda_p;

   i2cx_sync #(.W(2), .STAGES(STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (lines)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= lines[1];
         sda_p <= lines[0];
      end
   end

   assign scl_rise  = lines[1] & ~scl_p;
   assign scl_fall  = ~lines[1] & scl_p;
   assign start_det = scl_p & lines[1] & sda_p & ~lines[0];
   assign stop_det  = scl_p & lines[1] & ~sda_p & lines[0];
   assign sda_s     = lines[0];
endmodule

// File: rtl/i2cx_bank.sv
module i2cx_bank #(
   parameter int         NUM_REGS  = 24,
   parameter int         CNT_IDX   = 8,
   parameter logic [7:0] CNT_RST   = 8'h0F,
   parameter int         DEV_IDX   = 7,
   parameter int         VEN_IDX   = 6,
   parameter int         VEN_W     = 4,
   parameter int         STRAP_IDX = 1,
   parameter int         STRAP_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [7:0]         wr_addr,
   input  logic [7:0]         wr_data,
   input  logic [7:0]         rd_addr,
   output logic [7:0]         rd_data,
   output logic [7:0]         cnt_o,
   input  logic [7:0]         dev_id,
   input  logic [VEN_W-1:0]   vendor,
   input  logic [STRAP_W-1:0] strap
);
   logic [7:0] view [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      if (i == DEV_IDX) begin : g_id
         assign view[i] = dev_id;
      end else if (i == VEN_IDX) begin : g_ven
         logic [7-VEN_W:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else if (wr_en && wr_addr == 8'(i)) q <= wr_data[7:VEN_W];
         end
         assign view[i] = {q, vendor};
      end else if (i == STRAP_IDX) begin : g_strap
         logic [7-STRAP_W:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else if (wr_en && wr_addr == 8'(i)) q <= wr_data[7:STRAP_W];
         end
         assign view[i] = {q, strap};
      end else begin : g_rw
         localparam logic [7:0] RST = (i == CNT_IDX) ? CNT_RST : 8'h00;
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST;
            else if (wr_en && wr_addr == 8'(i)) q <= wr_data;
         end
         assign view[i] = q;
      end
   end

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_addr == 8'(i)) rd_data = view[i];
      end
   end

   assign cnt_o = view[CNT_IDX];
endmodule

// File: rtl/i2c_idx_regs.sv
module i2c_idx_regs
   import i2cx_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter int         NUM_REGS    = 24,
   parameter int         CNT_IDX     = 8,
   parameter logic [7:0] CNT_RST     = 8'h0F,
   parameter int         DEV_IDX     = 7,
   parameter int         VEN_IDX     = 6,
   parameter int         VEN_W       = 4,
   parameter int         STRAP_IDX   = 1,
   parameter int         STRAP_W     = 5,
   parameter int         SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe_o,
   output logic               wr_en_o,
   output logic [7:0]         wr_addr_o,
   output logic [7:0]         wr_data_o,
   input  logic [7:0]         dev_id_i,
   input  logic [VEN_W-1:0]   vendor_id_i,
   input  logic [STRAP_W-1:0] strap_i
);
   localparam logic [7:0] LAST_IDX = 8'(NUM_REGS - 1);

   if (NUM_REGS <= CNT_IDX || NUM_REGS > 256) begin : g_bad_depth
      $error("NUM_REGS must cover the length register and fit an 8-bit index");
   end
   if (DEV_IDX >= NUM_REGS || VEN_IDX >= NUM_REGS || STRAP_IDX >= NUM_REGS) begin : g_bad_ro
      $error("read-only registers must lie inside the bank");
   end
   if (CNT_IDX == DEV_IDX || CNT_IDX == VEN_IDX || CNT_IDX == STRAP_IDX ||
       DEV_IDX == VEN_IDX || DEV_IDX == STRAP_IDX || VEN_IDX == STRAP_IDX) begin : g_bad_map
      $error("special register indices must be distinct");
   end
   if (VEN_W < 1 || VEN_W > 7 || STRAP_W < 1 || STRAP_W > 7) begin : g_bad_fields
      $error("read-only field widths must be 1 to 7 bits");
   end

   logic scl_rise, scl_fall, start_det, stop_det, sda_s;

   i2cx_cond #(.STAGES(SYNC_STAGES)) u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_s     (sda_s)
   );

   xfer_st_t   st;
   wr_ph_t     ph;
   logic [2:0] bit_cnt;
   logic       byte_done;
   logic [7:0] shreg;
   logic [7:0] txsh;
   logic [7:0] idx;
   logic [7:0] left;
   logic       rd_mode;
   logic       host_ack;
   logic [7:0] rd_data;
   logic [7:0] len_reg;

   i2cx_bank #(
      .NUM_REGS  (NUM_REGS),
      .CNT_IDX   (CNT_IDX),
      .CNT_RST   (CNT_RST),
      .DEV_IDX   (DEV_IDX),
      .VEN_IDX   (VEN_IDX),
      .VEN_W     (VEN_W),
      .STRAP_IDX (STRAP_IDX),
      .STRAP_W   (STRAP_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_o),
      .wr_addr (wr_addr_o),
      .wr_data (wr_data_o),
      .rd_addr (idx),
      .rd_data (rd_data),
      .cnt_o   (len_reg),
      .dev_id  (dev_id_i),
      .vendor  (vendor_id_i),
      .strap   (strap_i)
   );

   function automatic logic [7:0] bump(input logic [7:0] v);
      return (v == 8'hFF) ? v : v + 8'd1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ph        <= PH_ADDR;
         bit_cnt   <= '0;
         byte_done <= 1'b0;
         shreg     <= '0;
         txsh      <= '1;
         idx       <= '0;
         left      <= '0;
         rd_mode   <= 1'b0;
         host_ack  <= 1'b0;
         wr_en_o   <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (start_det) begin
            st        <= ST_RX;
            ph        <= PH_ADDR;
            bit_cnt   <= '0;
            byte_done <= 1'b0;
         end else if (stop_det) begin
            st <= ST_IDLE;
         end else begin
            unique case (st)
               ST_RX: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[6:0], sda_s};
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) byte_done <= 1'b1;
                  end else if (scl_fall && byte_done) begin
                     byte_done <= 1'b0;
                     st        <= ST_ACK;
                     unique case (ph)
                        PH_ADDR: begin
                           if (shreg[7:1] == DEV_ADDR) begin
                              rd_mode <= shreg[0];
                              idx     <= '0;
                              left    <= len_reg;
                              ph      <= PH_INDEX;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                        PH_INDEX: begin
                           idx <= shreg;
                           ph  <= PH_COUNT;
                        end
                        PH_COUNT: begin
                           left <= shreg;
                           ph   <= PH_DATA;
                        end
                        PH_DATA: begin
                           if (left != 8'd0) begin
                              left <= left - 8'd1;
                              idx  <= bump(idx);
                              if (idx <= LAST_IDX) begin
                                 wr_en_o   <= 1'b1;
                                 wr_addr_o <= idx;
                                 wr_data_o <= shreg;
                              end
                           end
                        end
                        default: ;
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (rd_mode) begin
                        st   <= ST_TX;
                        txsh <= len_reg;
                     end else begin
                        st <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) byte_done <= 1'b1;
                  end else if (scl_fall) begin
                     if (byte_done) begin
                        byte_done <= 1'b0;
                        st        <= ST_RACK;
                     end else begin
                        txsh <= {txsh[6:0], 1'b1};
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     host_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (host_ack) begin
                        st      <= ST_TX;
                        bit_cnt <= '0;
                        if (left != 8'd0) begin
                           txsh <= rd_data;
                           left <= left - 8'd1;
                           idx  <= bump(idx);
                        end else begin
                           txsh <= 8'hFF;
                        end
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o = (st == ST_ACK) || (st == ST_TX && !txsh[7]);
endmodule

// File: rtl/i2cx_chk.sv
module i2cx_chk #(
   parameter int NUM_REGS = 24
) (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_i,
   input logic       sda_oe,
   input logic       wr_en,
   input logic [7:0] wr_addr,
   input logic       tx_active
);
   localparam logic [7:0] LAST = 8'(NUM_REGS - 1);

   always @(posedge clk) begin
      if (!rst_n) begin
         // R9
         reset_quiet_chk: assert (!sda_oe && !wr_en)
            else $error("bus driven or strobe raised during reset");
      end
   end

   // R10
   sda_lowscl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i)
      else $error("SDA drive changed while SCL high");

   // R2
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en)
      else $error("write strobe longer than one cycle");

   // R3
   wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_addr <= LAST)
      else $error("write strobe outside the bank");

   // R4
   tx_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_active |-> !wr_en)
      else $error("write strobe while sending");
endmodule

bind i2c_idx_regs i2cx_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_i     (scl_i),
   .sda_oe    (sda_oe_o),
   .wr_en     (wr_en_o),
   .wr_addr   (wr_addr_o),
   .tx_active (st == i2cx_pkg::ST_TX)
);

// File: tb/i2c_idx_regs_bench.sv
module i2c_idx_regs_bench;
   localparam int NREG = 24;
   localparam int H    = 10;
   localparam int Q    = 5;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n    = 1'b1;
   logic       host_scl = 1'b1;
   logic       host_sda = 1'b1;
   logic       sda_oe, wr_en;
   logic [7:0] wr_addr, wr_data;
   logic [7:0] dev_id = 8'h22;
   logic [3:0] ven    = 4'h1;
   logic [4:0] strap  = 5'h0A;
   logic       sda_bus;

   assign sda_bus = host_sda & ~sda_oe;

   i2c_idx_regs #(.NUM_REGS(NREG)) u_i2c_idx_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (host_scl),
      .sda_i       (sda_bus),
      .sda_oe_o    (sda_oe),
      .wr_en_o     (wr_en),
      .wr_addr_o   (wr_addr),
      .wr_data_o   (wr_data),
      .dev_id_i    (dev_id),
      .vendor_id_i (ven),
      .strap_i     (strap)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int pulses = 0;

   always @(posedge clk) if (rst_n && wr_en) pulses++;

   logic [7:0] model [NREG];
   logic [7:0] got [32];
   logic [7:0] got_cnt;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] mview(input int i);
      if (i >= NREG) return 8'h00;
      if (i == 7) return dev_id;
      if (i == 6) return {model[6][7:4], ven};
      if (i == 1) return {model[1][7:5], strap};
      return model[i];
   endfunction

   function automatic logic [7:0] exp_rd(input int k);
      return (k < int'(model[8])) ? mview(k) : 8'hFF;
   endfunction

   task automatic wt(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      host_sda = 1'b1; wt(Q);
      host_scl = 1'b1; wt(H);
      host_sda = 1'b0; wt(H);
      host_scl = 1'b0;
   endtask

   task automatic bus_stop();
      wt(Q); host_sda = 1'b0; wt(Q);
      host_scl = 1'b1; wt(H);
      host_sda = 1'b1; wt(H);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         wt(Q); host_sda = b[i]; wt(Q);
         host_scl = 1'b1; wt(H);
         host_scl = 1'b0;
      end
      wt(Q); host_sda = 1'b1; wt(Q);
      host_scl = 1'b1; wt(Q);
      ack = !sda_bus;
      wt(Q); host_scl = 1'b0;
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit nack);
      host_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wt(H); host_scl = 1'b1; wt(Q);
         b[i] = sda_bus;
         wt(Q); host_scl = 1'b0;
      end
      wt(Q); host_sda = nack; wt(Q);
      host_scl = 1'b1; wt(H);
      host_scl = 1'b0; wt(Q);
      host_sda = 1'b1;
   endtask

   task automatic wr_block(input int sidx, input int cnt, input int nsend,
                           input int seed, input string tag);
      int  p0;
      int  nexp;
      int  bad;
      bit  a;
      logic [7:0] v;
      p0 = pulses; nexp = 0; bad = 0;
      bus_start();
      send_byte(8'hD2, a);         if (!a) bad++;
      send_byte(8'(sidx), a);      if (!a) bad++;
      send_byte(8'(cnt), a);       if (!a) bad++;
      for (int k = 0; k < nsend; k++) begin
         v = 8'((seed + k * 29) & 255);
         send_byte(v, a);
         if (!a) bad++;
         if (k < cnt && sidx + k < NREG) begin
            model[sidx + k] = v;
            nexp++;
         end
      end
      bus_stop();
      chk(bad == 0, {tag, " acks"}, bad, 0);
      chk(pulses - p0 == nexp, {tag, " strobes"}, pulses - p0, nexp);
   endtask

   task automatic rd_block(input int n, input string tag);
      bit a;
      bus_start();
      send_byte(8'hD3, a);
      chk(a, "R1 read address ack", a, 1);
      recv_byte(got_cnt, n == 0);
      for (int k = 0; k < n; k++) recv_byte(got[k], k == n - 1);
      bus_stop();
      chk(got_cnt == model[8], "R4 length byte first", got_cnt, model[8]);
      for (int k = 0; k < n; k++)
         chk(got[k] == exp_rd(k), tag, got[k], exp_rd(k));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      bit a;
      int p0;
      for (int i = 0; i < NREG; i++) model[i] = 8'h00;
      model[8] = 8'h0F;

      #1 rst_n = 1'b0;
      wt(5);
      // R9 reset state at the ports
      chk(sda_oe == 1'b0, "R9 sda released in reset", sda_oe, 0);
      chk(wr_en == 1'b0, "R9 strobe low in reset", wr_en, 0);
      rst_n = 1'b1;
      wt(5);
      rd_block(15, "R9 reset contents");

      // R1 foreign address: no ack, bytes ignored
      p0 = pulses;
      bus_start();
      send_byte(8'hA0, a);
      chk(!a, "R1 foreign address ack", a, 0);
      send_byte(8'h00, a); chk(!a, "R1 ignored index ack", a, 0);
      send_byte(8'h02, a); chk(!a, "R1 ignored count ack", a, 0);
      send_byte(8'h55, a); chk(!a, "R1 ignored data ack", a, 0);
      send_byte(8'h66, a);
      bus_stop();
      chk(pulses == p0, "R1 no strobe", pulses - p0, 0);
      rd_block(15, "R1 bank unchanged");

      // R2 basic block write
      wr_block(2, 4, 4, 8'h31, "R2 block write");
      rd_block(15, "R2 readback");

      // R6 and R7 read-only overlays
      wr_block(6, 2, 2, 8'hFF, "R6 id write");
      wr_block(1, 1, 1, 8'hFF, "R7 strap write");
      rd_block(15, "R6/R7 overlays");

      // R5 length register and 0xFF fill
      wr_block(8, 1, 1, 20, "R5 length write");
      rd_block(22, "R5 length and fill");

      // R3 excess bytes and out-of-bank bytes
      wr_block(3, 2, 4, 8'h40, "R3 beyond count");
      wr_block(22, 4, 4, 8'h90, "R3 beyond bank");
      wr_block(8, 1, 1, 26, "R3 length 26");
      rd_block(26, "R3 readback with unimplemented zeros");

      // R2 sweep every index with one byte
      for (int n = 0; n < NREG; n++)
         wr_block(n, 1, 1, (n == 8) ? 24 : ((n * 37 + 5) & 255), "R2 sweep write");
      rd_block(24, "R2 sweep readback");

      // R8 host not-acknowledge ends the read
      bus_start();
      send_byte(8'hD3, a);
      recv_byte(got_cnt, 1'b0);
      recv_byte(got[0], 1'b0);
      recv_byte(got[1], 1'b1);
      chk(got[1] == exp_rd(1), "R8 last byte before nack", got[1], exp_rd(1));
      for (int p = 0; p < 9; p++) begin
         wt(Q); host_scl = 1'b1; wt(Q);
         chk(sda_bus == 1'b1, "R8 bus released after nack", sda_bus, 1);
         wt(Q); host_scl = 1'b0;
      end
      bus_stop();

      // R10 repeated start after an index: read still starts at register 0
      bus_start();
      send_byte(8'hD2, a);
      send_byte(8'h05, a);
      bus_start();
      send_byte(8'hD3, a);
      chk(a, "R10 repeated start ack", a, 1);
      recv_byte(got_cnt, 1'b0);
      recv_byte(got[0], 1'b0);
      recv_byte(got[1], 1'b1);
      bus_stop();
      chk(got_cnt == model[8], "R10 length after restart", got_cnt, model[8]);
      chk(got[0] == mview(0), "R10 first byte is register 0", got[0], mview(0));
      chk(got[1] == mview(1), "R10 second byte is register 1", got[1], mview(1));

      // R10 START in the middle of a write restarts address reception
      p0 = pulses;
      bus_start();
      send_byte(8'hD2, a); send_byte(8'd10, a); send_byte(8'd3, a);
      send_byte(8'h5A, a);
      bus_start();
      send_byte(8'hD2, a); send_byte(8'd11, a); send_byte(8'd1, a);
      send_byte(8'h77, a);
      bus_stop();
      model[10] = 8'h5A;
      model[11] = 8'h77;
      chk(pulses - p0 == 2, "R10 strobes across restart", pulses - p0, 2);
      rd_block(12, "R10 restart contents");

      // R6/R7 sweep of the read-only inputs
      for (int s = 0; s < 32; s++) begin
         strap  = 5'(s);
         ven    = 4'(s * 3);
         dev_id = 8'(s * 11 + 1);
         rd_block(8, "R6/R7 input sweep");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule